// File: doc/BRIEF.md
# Two-Wire Radio Coexistence Arbiter

This block decides, cycle by cycle, whether a WLAN MAC or a Bluetooth radio sharing the same 2.4 GHz band may use the air. The WLAN side presents separate transmit and receive requests, each with a priority flag. The Bluetooth side presents one asynchronous level that is high while it wants the medium for high-priority traffic. A static configuration input selects whether the two radios share one antenna or have one each.

The decision for every conflict comes from an eight-entry table. Each entry says whether WLAN may proceed and whether Bluetooth may proceed. Software can rewrite the table through a write-only address/data port, and reset loads it with defaults. Two holding rules sit on top of the table. A Bluetooth packet that has already been granted always runs to its end. A WLAN transfer whose table entry favours Bluetooth is cut off as soon as a fresh Bluetooth request is seen.

Top module: `coex_two_wire_arb`

## Requirements
- R1: During reset, and whenever neither side requests, `wl_grant_o`, `bt_grant_o` and `wl_active_o` are all low.
- R2: WLAN has no arbitration window. With no synchronized Bluetooth request, any WLAN request is granted combinationally in the cycle it is presented, and `wl_active_o` is high exactly while WLAN is granted.
- R3: `bt_pri_i` passes through a SYNC_STAGES-flop synchronizer (default 2). A change on it affects the grants only after that many rising clock edges.
- R4: The table index is {bit2 antenna mode, 1 = single; bit1 direction, 1 = Tx; bit0 WLAN priority, 1 = high}. Each entry is {bit1 WLAN may proceed, bit0 Bluetooth may proceed}. The single-antenna defaults are: low-priority Rx or Tx gives Bluetooth only (01), and high-priority Rx or Tx gives WLAN only (10).
- R5: The dual-antenna defaults are: Rx of either priority grants both sides (11), low-priority Tx gives Bluetooth only (01), and high-priority Tx gives WLAN only (10).
- R6: When a Bluetooth request appears while WLAN already holds a grant, or both appear together, the grants take the table entry. A WLAN transfer whose entry favours Bluetooth is revoked mid-packet.
- R7: Once Bluetooth has been granted, its grant stays high for as long as its request is held. A WLAN request that arrives later is granted only if its entry allows both sides at once; otherwise it waits.
- R8: When the Bluetooth request drops, a waiting WLAN request is granted as soon as the synchronized level is low, and `bt_grant_o` falls.
- R9: When WLAN requests Tx and Rx together, the entry is selected with the Tx direction and the Tx priority flag.
- R10: A cycle with `cfg_we_i` high replaces entry `cfg_addr_i` with `cfg_wdata_i` (same field layout as R4). The new value governs arbitration from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| single_ant_i | input | 1 | 1 = shared antenna, 0 = one antenna per radio |
| wl_tx_req_i | input | 1 | WLAN transmit request |
| wl_tx_hi_i | input | 1 | WLAN transmit is high priority |
| wl_rx_req_i | input | 1 | WLAN receive request |
| wl_rx_hi_i | input | 1 | WLAN receive is high priority |
| bt_pri_i | input | 1 | Bluetooth high-priority activity, asynchronous |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | 3 | Table entry index |
| cfg_wdata_i | input | 2 | Entry value {wl_ok, bt_ok} |
| wl_active_o | output | 1 | WLAN activity indication toward Bluetooth |
| wl_grant_o | output | 1 | WLAN may transmit or receive |
| bt_grant_o | output | 1 | Bluetooth may proceed |

## Verification
The bench builds the block with the default two-stage synchronizer, so the delay from `bt_pri_i` to the grants is a fixed two edges and can be sampled exactly. With only eight table entries, every entry is driven in both arrival orders: WLAN first with Bluetooth arriving later, and Bluetooth first with WLAN arriving later. This covers every default outcome, the revocation path, the holding path and the release path. A rewritten entry and the Tx-over-Rx selection are then checked against expectations computed from the index bits.

// File: rtl/coex2w_pkg.sv
package coex2w_pkg;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned NUM_ENT = 1 << IDX_W;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic wl_ok;
    logic bt_ok;
  } verdict_t;

  // index = {single_ant, is_tx, wl_hi}
  function automatic verdict_t default_verdict(idx_t idx);
    verdict_t v;
    case (idx)
      3'b000:  v = verdict_t'(2'b11);
      3'b001:  v = verdict_t'(2'b11);
      3'b010:  v = verdict_t'(2'b01);
      3'b011:  v = verdict_t'(2'b10);
      3'b100:  v = verdict_t'(2'b01);
      3'b101:  v = verdict_t'(2'b10);
      3'b110:  v = verdict_t'(2'b01);
      default: v = verdict_t'(2'b10);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/coex2w_sync.sv
module coex2w_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

  assert_sync_lag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(chain_q[STAGES-2]));
endmodule

// File: rtl/coex2w_table.sv
module coex2w_table
  import coex2w_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  idx_t     waddr_i,
  input  verdict_t wdata_i,
  input  idx_t     raddr_i,
  output verdict_t rdata_o
);
  verdict_t tab_q [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    localparam idx_t ENT_IDX = idx_t'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          tab_q[i] <= default_verdict(ENT_IDX);
      else if (we_i && waddr_i == ENT_IDX)  tab_q[i] <= wdata_i;
    end
  end

  assign rdata_o = tab_q[raddr_i];

  assert_write_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tab_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/coex2w_core.sv
module coex2w_core
  import coex2w_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     single_ant_i,
  input  logic     wl_tx_req_i,
  input  logic     wl_tx_hi_i,
  input  logic     wl_rx_req_i,
  input  logic     wl_rx_hi_i,
  input  logic     bt_req_i,
  input  verdict_t verdict_i,
  output idx_t     idx_o,
  output logic     wl_grant_o,
  output logic     bt_grant_o
);
  logic wl_req;
  logic wl_hi;
  logic bt_lock_q, wl_lock_q;

  assign wl_req = wl_tx_req_i | wl_rx_req_i;
  // Tx direction selects the entry when both are requested
  assign wl_hi  = wl_tx_req_i ? wl_tx_hi_i : wl_rx_hi_i;
  assign idx_o  = {single_ant_i, wl_tx_req_i, wl_hi};

  always_comb begin
    wl_grant_o = 1'b0;
    bt_grant_o = 1'b0;
    if (!bt_req_i) begin
      wl_grant_o = wl_req;
    end else if (!wl_req) begin
      bt_grant_o = 1'b1;
    end else if (bt_lock_q && !wl_lock_q) begin
      // Bluetooth already on air: late WLAN only if both may coexist
      bt_grant_o = 1'b1;
      wl_grant_o = verdict_i.wl_ok & verdict_i.bt_ok;
    end else begin
      wl_grant_o = verdict_i.wl_ok;
      bt_grant_o = verdict_i.bt_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bt_lock_q <= 1'b0;
      wl_lock_q <= 1'b0;
    end else begin
      bt_lock_q <= bt_req_i & bt_grant_o;
      wl_lock_q <= wl_req & wl_grant_o;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bt_req_i && !wl_req) |-> (!wl_grant_o && !bt_grant_o));

  assert_no_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bt_req_i && wl_req) |-> wl_grant_o);

  assert_bt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bt_grant_o && bt_req_i) |=> (bt_req_i -> bt_grant_o));

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bt_req_i) && wl_req) |-> (wl_grant_o && !bt_grant_o));
endmodule

// File: rtl/coex_two_wire_arb.sv
module coex_two_wire_arb
  import coex2w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       single_ant_i,
  input  logic       wl_tx_req_i,
  input  logic       wl_tx_hi_i,
  input  logic       wl_rx_req_i,
  input  logic       wl_rx_hi_i,
  input  logic       bt_pri_i,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_addr_i,
  input  logic [1:0] cfg_wdata_i,
  output logic       wl_active_o,
  output logic       wl_grant_o,
  output logic       bt_grant_o
);
  logic     bt_sync;
  idx_t     idx;
  verdict_t verdict;
  logic     wl_grant;

  coex2w_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (bt_pri_i),
    .sync_o  (bt_sync)
  );

  coex2w_table i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (idx_t'(cfg_addr_i)),
    .wdata_i (verdict_t'(cfg_wdata_i)),
    .raddr_i (idx),
    .rdata_o (verdict)
  );

  coex2w_core i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .single_ant_i (single_ant_i),
    .wl_tx_req_i  (wl_tx_req_i),
    .wl_tx_hi_i   (wl_tx_hi_i),
    .wl_rx_req_i  (wl_rx_req_i),
    .wl_rx_hi_i   (wl_rx_hi_i),
    .bt_req_i     (bt_sync),
    .verdict_i    (verdict),
    .idx_o        (idx),
    .wl_grant_o   (wl_grant),
    .bt_grant_o   (bt_grant_o)
  );

  assign wl_grant_o  = wl_grant;
  assign wl_active_o = wl_grant;
endmodule

// File: tb/test_coex_two_wire_arb.sv
module test_coex_two_wire_arb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       single_ant = 1'b0;
  logic       tx_req = 1'b0, tx_hi = 1'b0, rx_req = 1'b0, rx_hi = 1'b0;
  logic       bt_pri = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [1:0] cfg_wdata = '0;
  logic       wl_active, wl_grant, bt_grant;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] exp_tab [8];

  always #5 clk = ~clk;

  coex_two_wire_arb i_coex_two_wire_arb (
    .clk_i(clk), .rst_ni(rst_ni), .single_ant_i(single_ant),
    .wl_tx_req_i(tx_req), .wl_tx_hi_i(tx_hi), .wl_rx_req_i(rx_req), .wl_rx_hi_i(rx_hi),
    .bt_pri_i(bt_pri), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .wl_active_o(wl_active), .wl_grant_o(wl_grant), .bt_grant_o(bt_grant)
  );

  // Defaults from R4/R5: high priority -> WLAN wins; low -> Bluetooth wins;
  // dual-antenna Rx also grants the other side.
  function automatic logic [1:0] calc_default(logic [2:0] idx);
    logic coexist;
    coexist = !idx[2] && !idx[1];
    if (idx[0]) return {1'b1, coexist};
    else        return {coexist, 1'b1};
  endfunction

  task automatic chk(string req, logic exp_wl, logic exp_bt);
    checks++;
    if (wl_grant !== exp_wl || bt_grant !== exp_bt || wl_active !== exp_wl) begin
      errors++;
      $display("FAIL %s: wl_grant=%b bt_grant=%b wl_active=%b expected wl=%b bt=%b act=%b",
               req, wl_grant, bt_grant, wl_active, exp_wl, exp_bt, exp_wl);
    end
  endtask

  task automatic drive_wl(logic [2:0] idx);
    single_ant = idx[2];
    if (idx[1]) begin tx_req = 1'b1; tx_hi = idx[0]; end
    else        begin rx_req = 1'b1; rx_hi = idx[0]; end
  endtask

  task automatic go_quiet();
    tx_req = 0; tx_hi = 0; rx_req = 0; rx_hi = 0; bt_pri = 0;
    repeat (4) @(negedge clk);
    #1 chk("R1 idle", 1'b0, 1'b0);
  endtask

  // WLAN first, Bluetooth arrives later
  task automatic wl_first(logic [2:0] idx);
    logic [1:0] e;
    e = exp_tab[idx];
    @(negedge clk);
    drive_wl(idx);
    #1 chk("R2 same-cycle grant", 1'b1, 1'b0);
    bt_pri = 1'b1;
    @(negedge clk);
    #1 chk("R3 one edge after bt", 1'b1, 1'b0);
    @(negedge clk);
    #1 chk(idx[2] ? "R4/R6 bt arrives" : "R5/R6 bt arrives", e[1], e[0]);
    @(negedge clk);
    #1 chk("R6 steady", e[1], e[0]);
    go_quiet();
  endtask

  // Bluetooth first, WLAN arrives later
  task automatic bt_first(logic [2:0] idx);
    logic [1:0] e;
    e = exp_tab[idx];
    @(negedge clk);
    single_ant = idx[2];
    bt_pri = 1'b1;
    @(negedge clk);
    #1 chk("R3 bt not yet seen", 1'b0, 1'b0);
    @(negedge clk);
    #1 chk("R7 bt alone", 1'b0, 1'b1);
    @(negedge clk);
    drive_wl(idx);
    #1 chk("R7 late wl waits", e[1] & e[0], 1'b1);
    @(negedge clk);
    #1 chk("R7 bt kept", e[1] & e[0], 1'b1);
    bt_pri = 1'b0;
    @(negedge clk);
    #1 chk("R3 drop not yet seen", e[1] & e[0], 1'b1);
    @(negedge clk);
    #1 chk("R8 wl released", 1'b1, 1'b0);
    go_quiet();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_tab[i] = calc_default(3'(i));
    #3 chk("R1 in reset", 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1 chk("R1 after reset", 1'b0, 1'b0);

    for (int i = 0; i < 8; i++) wl_first(3'(i));
    for (int i = 0; i < 8; i++) bt_first(3'(i));

    // R9: Tx low with Rx high, single antenna -> entry 110 (Bluetooth only)
    @(negedge clk);
    single_ant = 1; tx_req = 1; tx_hi = 0; rx_req = 1; rx_hi = 1;
    bt_pri = 1;
    repeat (2) @(negedge clk);
    #1 chk("R9 tx selects entry", exp_tab[3'b110][1], exp_tab[3'b110][0]);
    go_quiet();

    // R10: rewrite dual Tx high (011) to Bluetooth only, and dual Rx low (000) to WLAN only
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'b011; cfg_wdata = 2'b01;
    @(negedge clk);
    cfg_addr = 3'b000; cfg_wdata = 2'b10;
    @(negedge clk);
    cfg_we = 0;
    exp_tab[3'b011] = 2'b01;
    exp_tab[3'b000] = 2'b10;
    wl_first(3'b011);
    wl_first(3'b000);
    bt_first(3'b000);
    // R10: write back the default and recheck
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'b011; cfg_wdata = calc_default(3'b011);
    @(negedge clk);
    cfg_we = 0;
    exp_tab[3'b011] = calc_default(3'b011);
    wl_first(3'b011);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule